// File: doc/BRIEF.md
# Accumulator Micro-Step Sequencer

This block is a small accumulator processor built around a control state machine. Each instruction is carried out as a fixed series of register transfers, one per clock. A single synchronous memory port serves both instruction fetch and data access, and every access passes through two staging registers. The address register drives the memory address. The buffer register receives read data and supplies write data. A program counter, an instruction register and one accumulator complete the register set.

Fetching takes five clocks, always in this order:

1. The program counter is copied into the address register.
2. The design waits one clock for the memory's read latency.
3. The read word is captured into the buffer register.
4. The program counter is incremented.
5. The buffer register is copied into the instruction register.

A decode clock follows. Execution then uses the same address-register and buffer-register path for operand reads and stores. The sequencer runs from reset until it reaches a halt instruction. After that it stays frozen until the next reset.

Top module: `acc_seq`

## Requirements
- R1: While reset is held and in the first cycle after reset, the program counter, accumulator and instruction register read zero, `halt_o` is low, `mem_we` is low and `mem_addr` is zero.
- R2: A fetch follows the fixed order given above. Counting clock edges after reset release, `mem_addr` equals the program counter for the first two cycles. `pc_o` increments at edge 4, `ir_o` takes the fetched word at edge 5, and decode occupies the sixth cycle.
- R3: An instruction is one 8-bit word. Bits [7:5] hold the opcode and bits [4:0] hold a direct operand address, which is zero-extended to the 8-bit memory address. The opcodes are: 1 load, 2 add, 3 store, 4 jump, 7 halt.
- R4: Load sets the accumulator to the memory word at the operand address. The instruction takes 10 cycles in total, and the accumulator changes only at its last edge.
- R5: Add sets the accumulator to the accumulator plus the memory word at the operand address, wrapping modulo 256. The instruction takes 10 cycles.
- R6: Store writes the accumulator to the operand address through the buffer register. It asserts `mem_we` for exactly one cycle, with `mem_wdata` equal to the accumulator and `mem_addr` equal to the operand address. The instruction takes 9 cycles.
- R7: Jump loads the operand address into the program counter and takes 6 cycles.
- R8: Halt raises `halt_o` 6 cycles after its fetch begins, with the program counter one past the halt word. From then until reset, the program counter and accumulator hold their values and no memory write occurs.
- R9: Opcodes 0, 5 and 6 behave as no-ops. Each takes 6 cycles and leaves the accumulator and memory unchanged.
- R10: The program counter changes only by +1 during a fetch, or by a jump loading the operand of the jump instruction held in the instruction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | Memory address, driven by the address register |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data, driven by the buffer register |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| pc_o | output | 8 | Program counter |
| acc_o | output | 8 | Accumulator |
| ir_o | output | 8 | Instruction register |
| halt_o | output | 1 | Sequencer is halted |

## Verification
A wrong micro-step is visible at the ports within one clock. It shows up as a program counter or instruction register that changes at the wrong edge, or as `mem_addr` presenting the wrong source while a read is pending. A wrong operand path or a wrong adder result appears as an incorrect accumulator value at the end of that instruction. It also corrupts the stored memory image when the program finishes. A missing or extra state changes the total cycle count before `halt_o` rises, so every random program is timed against a per-opcode cycle budget.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

   localparam int OPC_W = 3;

   localparam logic [OPC_W-1:0] OPC_LOAD  = 3'd1;
   localparam logic [OPC_W-1:0] OPC_ADD   = 3'd2;
   localparam logic [OPC_W-1:0] OPC_STORE = 3'd3;
   localparam logic [OPC_W-1:0] OPC_JUMP  = 3'd4;
   localparam logic [OPC_W-1:0] OPC_HALT  = 3'd7;

   typedef enum logic [3:0] {
      ST_F_ADDR,
      ST_F_WAIT,
      ST_F_CAPT,
      ST_F_INCR,
      ST_F_INST,
      ST_DECODE,
      ST_X_ADDR,
      ST_X_WAIT,
      ST_X_CAPT,
      ST_X_ALU,
      ST_X_STAGE,
      ST_X_WRITE,
      ST_STOPPED
   } step_e;

   typedef struct packed {
      logic mar_from_pc;
      logic mar_from_opnd;
      logic mbr_from_mem;
      logic mbr_from_acc;
      logic pc_incr;
      logic pc_jump;
      logic ir_load;
      logic acc_load;
      logic acc_add;
      logic mem_write;
      logic stopped;
   } xfer_t;

endpackage

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
   import acc_seq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] opcode,
   output xfer_t            xfer
);

   step_e step_q, step_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= ST_F_ADDR;
      else        step_q <= step_d;
   end

   always_comb begin
      xfer   = '0;
      step_d = step_q;
      case (step_q)
         ST_F_ADDR: begin
            xfer.mar_from_pc = 1'b1;
            step_d = ST_F_WAIT;
         end
         ST_F_WAIT: step_d = ST_F_CAPT;
         ST_F_CAPT: begin
            xfer.mbr_from_mem = 1'b1;
            step_d = ST_F_INCR;
         end
         ST_F_INCR: begin
            xfer.pc_incr = 1'b1;
            step_d = ST_F_INST;
         end
         ST_F_INST: begin
            xfer.ir_load = 1'b1;
            step_d = ST_DECODE;
         end
         ST_DECODE: begin
            case (opcode)
               OPC_LOAD, OPC_ADD, OPC_STORE: step_d = ST_X_ADDR;
               OPC_JUMP: begin
                  xfer.pc_jump = 1'b1;
                  step_d = ST_F_ADDR;
               end
               OPC_HALT: step_d = ST_STOPPED;
               default:  step_d = ST_F_ADDR;
            endcase
         end
         ST_X_ADDR: begin
            xfer.mar_from_opnd = 1'b1;
            step_d = (opcode == OPC_STORE) ? ST_X_STAGE : ST_X_WAIT;
         end
         ST_X_WAIT: step_d = ST_X_CAPT;
         ST_X_CAPT: begin
            xfer.mbr_from_mem = 1'b1;
            step_d = ST_X_ALU;
         end
         ST_X_ALU: begin
            xfer.acc_load = 1'b1;
            xfer.acc_add  = (opcode == OPC_ADD);
            step_d = ST_F_ADDR;
         end
         ST_X_STAGE: begin
            xfer.mbr_from_acc = 1'b1;
            step_d = ST_X_WRITE;
         end
         ST_X_WRITE: begin
            xfer.mem_write = 1'b1;
            step_d = ST_F_ADDR;
         end
         ST_STOPPED: xfer.stopped = 1'b1;
         default:    step_d = ST_F_ADDR;
      endcase
   end

endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] operand,
   input  logic              do_add,
   output logic [DATA_W-1:0] result
);

   always_comb begin
      if (do_add) result = acc + operand;
      else        result = operand;
   end

endmodule

// File: rtl/acc_seq_regs.sv
module acc_seq_regs
   import acc_seq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  xfer_t             xfer,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] alu_y,
   output logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] mar,
   output logic [DATA_W-1:0] mbr,
   output logic [DATA_W-1:0] ir,
   output logic [DATA_W-1:0] acc
);

   localparam int OPND_W = DATA_W - OPC_W;

   logic [ADDR_W-1:0] opnd_addr;

   generate
      if (ADDR_W == OPND_W) begin : g_opnd_full
         assign opnd_addr = ir[OPND_W-1:0];
      end else begin : g_opnd_pad
         assign opnd_addr = {{(ADDR_W-OPND_W){1'b0}}, ir[OPND_W-1:0]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc  <= '0;
         mar <= '0;
         mbr <= '0;
         ir  <= '0;
         acc <= '0;
      end else begin
         if (xfer.mar_from_pc)        mar <= pc;
         else if (xfer.mar_from_opnd) mar <= opnd_addr;

         if (xfer.mbr_from_mem)       mbr <= mem_rdata;
         else if (xfer.mbr_from_acc)  mbr <= acc;

         if (xfer.pc_incr)            pc  <= pc + ADDR_W'(1);
         else if (xfer.pc_jump)       pc  <= opnd_addr;

         if (xfer.ir_load)            ir  <= mbr;
         if (xfer.acc_load)           acc <= alu_y;
      end
   end

endmodule

// File: rtl/acc_seq.sv
module acc_seq
   import acc_seq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] pc_o,
   output logic [DATA_W-1:0] acc_o,
   output logic [DATA_W-1:0] ir_o,
   output logic              halt_o
);

   localparam int OPND_W = DATA_W - OPC_W;

   generate
      if (OPND_W < 1) begin : g_bad_data_w
         $error("acc_seq: DATA_W must exceed the opcode width");
      end
      if (ADDR_W < OPND_W) begin : g_bad_addr_w
         $error("acc_seq: ADDR_W must hold the operand field");
      end
   endgenerate

   xfer_t             xfer;
   logic [ADDR_W-1:0] pc, mar;
   logic [DATA_W-1:0] mbr, ir, acc, alu_y;

   acc_seq_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .opcode (ir[DATA_W-1 -: OPC_W]),
      .xfer   (xfer)
   );

   acc_seq_alu #(.DATA_W(DATA_W)) u_alu (
      .acc     (acc),
      .operand (mbr),
      .do_add  (xfer.acc_add),
      .result  (alu_y)
   );

   acc_seq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .xfer      (xfer),
      .mem_rdata (mem_rdata),
      .alu_y     (alu_y),
      .pc        (pc),
      .mar       (mar),
      .mbr       (mbr),
      .ir        (ir),
      .acc       (acc)
   );

   assign mem_addr  = mar;
   assign mem_wdata = mbr;
   assign mem_we    = xfer.mem_write;
   assign pc_o      = pc;
   assign acc_o     = acc;
   assign ir_o      = ir;
   assign halt_o    = xfer.stopped;

endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk
   import acc_seq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_we,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [ADDR_W-1:0] pc_o,
   input logic [DATA_W-1:0] acc_o,
   input logic [DATA_W-1:0] ir_o,
   input logic              halt_o
);

   localparam int OPND_W = DATA_W - OPC_W;

   logic [ADDR_W-1:0]  ir_target;
   logic [OPC_W-1:0]   ir_op;
   assign ir_target = ADDR_W'(ir_o[OPND_W-1:0]);
   assign ir_op     = ir_o[DATA_W-1 -: OPC_W];

   // R8: once stopped, stays stopped
   p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halt_o |=> halt_o);

   // R8: nothing moves after stopping
   p_halt_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halt_o |=> ($stable(pc_o) && $stable(acc_o) && !mem_we));

   // R6: a write lasts one cycle
   p_write_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   // R6: write carries the accumulator to the store operand
   p_write_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_wdata == acc_o && mem_addr == ir_target && ir_op == OPC_STORE));

   // R10: program counter moves by one or by a jump
   p_pc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pc_o) |->
         (pc_o == $past(pc_o) + ADDR_W'(1)) || (ir_op == OPC_JUMP && pc_o == ir_target));

   // R4: accumulator changes only under load or add
   p_acc_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(acc_o) |-> (ir_op == OPC_LOAD || ir_op == OPC_ADD));

endmodule

bind acc_seq acc_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_addr  (mem_addr),
   .mem_we    (mem_we),
   .mem_wdata (mem_wdata),
   .pc_o      (pc_o),
   .acc_o     (acc_o),
   .ir_o      (ir_o),
   .halt_o    (halt_o)
);

// File: tb/tb_acc_seq.sv
module tb_acc_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] mem_addr, mem_wdata, pc_o, acc_o, ir_o;
   logic [7:0] mem_rdata;
   logic       mem_we, halt_o;

   acc_seq dut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_o(pc_o),
      .acc_o(acc_o), .ir_o(ir_o), .halt_o(halt_o)
   );

   always #5 clk = ~clk;

   // bench memory: 32 words, loaded while reset is held
   logic [7:0] bmem [32];
   logic       ld_en = 1'b0;
   logic [4:0] ld_addr = '0;
   logic [7:0] ld_data = '0;

   always @(posedge clk) begin
      if (ld_en)       bmem[ld_addr] <= ld_data;
      else if (mem_we) bmem[mem_addr[4:0]] <= mem_wdata;
      mem_rdata <= bmem[mem_addr[4:0]];
   end

   int wr_cnt;
   always @(negedge clk) begin
      if (!rst_n)      wr_cnt <= 0;
      else if (mem_we) wr_cnt <= wr_cnt + 1;
   end

   int n_chk = 0, n_bad = 0, wd = 0;
   always @(posedge clk) begin
      wd <= wd + 1;
      if (wd > 150000) begin
         $display("FAIL watchdog: act=%0d exp<=150000 cycles", wd);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad + 1);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   logic [7:0] prog [32];
   logic [7:0] emem [32];
   logic [7:0] e_acc, e_pc;
   int         e_cyc, e_wr;

   function automatic logic [7:0] ins(input int op, input int a);
      return {3'(op), 5'(a)};
   endfunction

   // instruction-level model with per-opcode cycle budget
   task automatic model();
      logic [7:0] w;
      logic [4:0] a;
      e_acc = 0; e_pc = 0; e_cyc = 0; e_wr = 0;
      for (int i = 0; i < 32; i++) emem[i] = prog[i];
      for (int s = 0; s < 200; s++) begin
         w = emem[e_pc[4:0]];
         e_pc = e_pc + 8'd1;
         a = w[4:0];
         case (w[7:5])
            3'd1: begin e_acc = emem[a]; e_cyc += 10; end
            3'd2: begin e_acc = e_acc + emem[a]; e_cyc += 10; end
            3'd3: begin emem[a] = e_acc; e_wr++; e_cyc += 9; end
            3'd4: begin e_pc = {3'b000, a}; e_cyc += 6; end
            3'd7: begin e_cyc += 6; break; end
            default: e_cyc += 6;
         endcase
      end
   endtask

   task automatic load_and_reset();
      rst_n = 1'b0;
      for (int i = 0; i < 32; i++) begin
         @(negedge clk);
         ld_en = 1'b1; ld_addr = 5'(i); ld_data = prog[i];
      end
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic run_prog(input string tag);
      int edges, bad_words;
      logic [7:0] hold_pc, hold_acc;
      int hold_wr;
      model();
      load_and_reset();
      rst_n = 1'b1;
      edges = 0;
      while (!halt_o && edges < 3000) begin
         @(posedge clk);
         edges++;
         @(negedge clk);
      end
      chk({tag, " R2/R4/R6/R7/R9 cycle budget"}, edges, e_cyc);
      chk({tag, " R4/R5 accumulator"}, acc_o, e_acc);
      chk({tag, " R8 pc after halt"}, pc_o, e_pc);
      chk({tag, " R6 write count"}, wr_cnt, e_wr);
      bad_words = 0;
      for (int i = 0; i < 32; i++) if (bmem[i] !== emem[i]) bad_words++;
      chk({tag, " R6 memory image"}, bad_words, 0);
      hold_pc = pc_o; hold_acc = acc_o; hold_wr = wr_cnt;
      repeat (8) @(negedge clk);
      chk({tag, " R8 still halted"}, halt_o, 1);
      chk({tag, " R8 frozen pc/acc/writes"}, {pc_o, acc_o, 16'(wr_cnt)},
          {hold_pc, hold_acc, 16'(hold_wr)});
   endtask

   initial begin
      int op;
      void'($urandom(32'd20240611));

      // R1: reset state, and R2 fetch order on a load
      for (int i = 0; i < 32; i++) prog[i] = 8'h00;
      prog[0]  = ins(1, 20);
      prog[1]  = ins(7, 0);
      prog[20] = 8'h5A;
      load_and_reset();
      chk("R1 reset outputs", {pc_o, acc_o, ir_o, 6'b0, halt_o, mem_we}, 32'h0);
      chk("R1 reset mem_addr", mem_addr, 0);
      rst_n = 1'b1;
      chk("R2 cycle0 address from pc", mem_addr, 0);
      repeat (3) @(negedge clk);
      chk("R2 pc not yet incremented at edge3", pc_o, 0);
      @(negedge clk);
      chk("R2 pc incremented at edge4, ir still old", {pc_o, ir_o}, {8'd1, 8'd0});
      @(negedge clk);
      chk("R2 ir loaded at edge5", ir_o, ins(1, 20));
      repeat (2) @(negedge clk);
      chk("R3 operand address zero-extended", mem_addr, 20);
      repeat (2) @(negedge clk);
      chk("R4 acc unchanged before last edge", acc_o, 0);
      @(negedge clk);
      chk("R4 load result at edge10", acc_o, 8'h5A);

      // R5/R6: add with wrap, then store
      for (int i = 0; i < 32; i++) prog[i] = 8'h00;
      prog[0] = ins(1, 20); prog[1] = ins(2, 21); prog[2] = ins(3, 22); prog[3] = ins(7, 0);
      prog[20] = 8'hF0; prog[21] = 8'h20;
      run_prog("add-wrap R5");
      chk("R5 wrapped sum stored", bmem[22], 8'h10);

      // R9: unknown opcodes
      for (int i = 0; i < 32; i++) prog[i] = 8'h00;
      prog[0] = ins(5, 3); prog[1] = ins(6, 9); prog[2] = ins(0, 1); prog[3] = ins(7, 0);
      run_prog("noop R9");

      // R7: jump over a store
      for (int i = 0; i < 32; i++) prog[i] = 8'h00;
      prog[0] = ins(4, 3); prog[1] = ins(3, 16); prog[3] = ins(7, 0);
      run_prog("jump R7");

      // random programs
      for (int t = 0; t < 40; t++) begin
         for (int i = 0; i < 16; i++) begin
            op = $urandom % 8;
            if (op == 3)      prog[i] = ins(3, 16 + $urandom % 16);
            else if (op == 4) prog[i] = ins(4, i + 1 + $urandom % (16 - i - 1 + 1 > 0 ? 15 - i + 1 : 1));
            else              prog[i] = ins(op, $urandom % 32);
            if (op == 4 && prog[i][4:0] > 15) prog[i] = ins(4, 15);
         end
         prog[15] = ins(7, 0);
         for (int i = 16; i < 32; i++) prog[i] = 8'($urandom);
         run_prog("random R3");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule